// File: doc/BRIEF.md
# Multi-channel bus bridging DMA controller

This block is an eight-channel byte mover that sits between a wide memory bus (24-bit address: an 8-bit bank above a 16-bit offset) and a narrow peripheral bus whose registers all live in one 256-byte page at 0x2100–0x21FF. The CPU programs each channel through a byte-wide register window and then writes a start mask. The engine runs every selected channel to completion, one after another, and raises `busy` for the whole run so that the processor can be held off.

Each channel has a mode byte, a peripheral register low byte, a 16-bit memory offset with its bank, and a 16-bit byte count. The mode byte sets the transfer direction and the way the memory offset moves after each byte: up, down, or held still for fills. It also picks a short repeating sequence of offsets that is added to the peripheral register, so that one channel can feed a register pair such as a word-wide data port. Every byte costs a fixed number of clock cycles. In those cycles there is one read strobe on the source bus and one write strobe on the destination bus.

Top module: `dma_bridge`

## Requirements
- R1: Channel n owns the 16-byte slot at 0x4300+16·n. Its offsets are: 0 mode, 1 peripheral low byte, 2/3 memory offset (low byte, high byte), 4 bank, 5/6 byte count (low byte, high byte). `cpu_rdata` returns the byte at the address presented one cycle earlier. Offsets 7–15, addresses outside 0x4300–0x437F and the start address all read 0. After reset every register reads 0.
- R2: A write to 0x420B while idle starts the channels whose bits are set, with bit n selecting channel n. `busy` is high from the clock edge that takes a nonzero mask until the last selected channel has finished. While `busy` is low no bus strobe is asserted.
- R3: Channels started together run one at a time in ascending channel order. Each channel moves all of its bytes before the next one begins.
- R4: Mode bit 7 = 0 reads the memory bus (`a_rd`) and writes the peripheral bus (`b_wr`). Mode bit 7 = 1 reads the peripheral bus (`b_rd`) and writes the memory bus (`a_wr`). The written byte is the byte that was read.
- R5: Mode bits 4:3 move the memory offset after each byte: 0 adds one, 2 subtracts one, 1 and 3 hold it. The offset wraps within 16 bits and the bank never changes.
- R6: Mode bits 2:0 pick the peripheral offset sequence: 0 gives 0; 1 gives 0,1; 2 gives 0,0; 3 gives 0,0,1,1; 4 gives 0,1,2,3; 5 gives 0,1,0,1; 6 behaves as 2 and 7 behaves as 3. The sequence starts from its first entry when each channel begins.
- R7: The peripheral address is page 0x21 with low byte (programmed low byte + sequence offset) mod 256. Port `b_addr` carries that low byte.
- R8: Every byte takes CYC_PER_BYTE cycles (at least 3). The read strobe lasts one cycle. The source returns its data on the cycle after the strobe. The write strobe comes CYC_PER_BYTE−1 cycles after the read strobe.
- R9: When a channel finishes, its count reads 0 and its memory offset reads the value after the last step. A count of 0 means 65536 bytes, and the count register counts down while the channel runs.
- R10: Mode bits 6 and 5 are stored and read back but change nothing about a transfer.
- R11: Register writes and start writes made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read data for the previous cycle's address |
| busy | output | 1 | Transfer in progress; stall the CPU |
| a_addr | output | 24 | Memory bus address {bank, offset} |
| a_rd | output | 1 | Memory bus read strobe |
| a_wr | output | 1 | Memory bus write strobe |
| a_wdata | output | 8 | Memory bus write data |
| a_rdata | input | 8 | Memory bus read data, valid the cycle after `a_rd` |
| b_addr | output | 8 | Peripheral register low byte within page 0x21 |
| b_rd | output | 1 | Peripheral bus read strobe |
| b_wr | output | 1 | Peripheral bus write strobe |
| b_wdata | output | 8 | Peripheral bus write data |
| b_rdata | input | 8 | Peripheral bus read data, valid the cycle after `b_rd` |

## Verification
The bench goes after the places where the offset arithmetic wraps. It runs an incrementing transfer across offset 0xFFFF and a decrementing one across 0x0000; a design that carried into the bank would corrupt the memory-bus addresses. It also runs a peripheral low byte of 0xFE with the four-step sequence, which catches a design that spills out of page 0x21. Mixed start masks with randomized modes compare the full ordered list of writes against a bench model. That list exposes channels run out of order, sequences that fail to restart per channel, and the aliased codes 6/7 or step 3 decoded wrongly. Writes made during a run must leave both the registers and the transfer untouched. A zero count must count down from 65536 instead of stopping at once.

// File: rtl/dma_bridge_pkg.sv
package dma_bridge_pkg;

  localparam int unsigned DIR_BIT  = 7;
  localparam int unsigned STEP_LSB = 3;
  localparam int unsigned PAT_LSB  = 0;

  typedef enum logic [1:0] {
    STEP_UP    = 2'd0,
    STEP_HOLD  = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_HOLDX = 2'd3
  } step_e;

  // Peripheral offset for a given sequence code and per-channel byte index.
  function automatic logic [1:0] pat_offset(input logic [2:0] code, input logic [1:0] idx);
    logic [1:0] r;
    case (code)
      3'd1, 3'd5: r = {1'b0, idx[0]};
      3'd3, 3'd7: r = {1'b0, idx[1]};
      3'd4:       r = idx;
      default:    r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned NCH      = 8,
  parameter logic [15:0] WIN_BASE = 16'h4300,
  localparam int unsigned CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lock,
  input  logic           cpu_we,
  input  logic [15:0]    cpu_addr,
  input  logic [7:0]     cpu_wdata,
  output logic [7:0]     cpu_rdata,
  input  logic [CHW-1:0] sel_ch,
  output logic           sel_dir,
  output logic [1:0]     sel_step,
  output logic [2:0]     sel_pat,
  output logic [7:0]     sel_blow,
  output logic [15:0]    sel_addr,
  output logic [7:0]     sel_bank,
  output logic [15:0]    sel_cnt,
  input  logic           upd_en,
  input  logic [15:0]    upd_addr,
  input  logic [15:0]    upd_cnt
);
  import dma_bridge_pkg::*;

  localparam logic [15:0] WIN_SPAN = 16'(16 * NCH);

  logic [7:0]  mode_q [NCH];
  logic [7:0]  blow_q [NCH];
  logic [15:0] addr_q [NCH];
  logic [7:0]  bank_q [NCH];
  logic [15:0] cnt_q  [NCH];

  logic [15:0]    rel;
  logic           in_win;
  logic [CHW-1:0] wch;
  logic [3:0]     off;

  assign rel    = cpu_addr - WIN_BASE;
  assign in_win = (cpu_addr >= WIN_BASE) && (rel < WIN_SPAN);
  assign wch    = rel[4 +: CHW];
  assign off    = rel[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        blow_q[i] <= '0;
        addr_q[i] <= '0;
        bank_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else if (upd_en) begin
      addr_q[sel_ch] <= upd_addr;
      cnt_q[sel_ch]  <= upd_cnt;
    end else if (cpu_we && in_win && !lock) begin
      case (off)
        4'd0: mode_q[wch]        <= cpu_wdata;
        4'd1: blow_q[wch]        <= cpu_wdata;
        4'd2: addr_q[wch][7:0]   <= cpu_wdata;
        4'd3: addr_q[wch][15:8]  <= cpu_wdata;
        4'd4: bank_q[wch]        <= cpu_wdata;
        4'd5: cnt_q[wch][7:0]    <= cpu_wdata;
        4'd6: cnt_q[wch][15:8]   <= cpu_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else begin
      cpu_rdata <= '0;
      if (in_win) begin
        case (off)
          4'd0: cpu_rdata <= mode_q[wch];
          4'd1: cpu_rdata <= blow_q[wch];
          4'd2: cpu_rdata <= addr_q[wch][7:0];
          4'd3: cpu_rdata <= addr_q[wch][15:8];
          4'd4: cpu_rdata <= bank_q[wch];
          4'd5: cpu_rdata <= cnt_q[wch][7:0];
          4'd6: cpu_rdata <= cnt_q[wch][15:8];
          default: cpu_rdata <= '0;
        endcase
      end
    end
  end

  assign sel_dir  = mode_q[sel_ch][DIR_BIT];
  assign sel_step = mode_q[sel_ch][STEP_LSB +: 2];
  assign sel_pat  = mode_q[sel_ch][PAT_LSB +: 3];
  assign sel_blow = blow_q[sel_ch];
  assign sel_addr = addr_q[sel_ch];
  assign sel_bank = bank_q[sel_ch];
  assign sel_cnt  = cnt_q[sel_ch];

endmodule

// File: rtl/dma_chan_pick.sv
module dma_chan_pick #(
  parameter int unsigned NCH  = 8,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend,
  output logic [CHW-1:0] pick_ch
);
  // Lowest pending channel wins: scan downward so the last hit is the lowest.
  logic [CHW-1:0] stage [NCH+1];
  assign stage[NCH] = '0;

  for (genvar g = NCH - 1; g >= 0; g--) begin : g_scan
    assign stage[g] = pend[g] ? CHW'(g) : stage[g+1];
  end

  assign pick_ch = stage[0];

endmodule

// File: rtl/dma_byte_engine.sv
module dma_byte_engine #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CPB  = 4,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned PHW = $clog2(CPB)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [CHW-1:0] pick_ch,
  input  logic           dir,
  input  logic [1:0]     step,
  input  logic [2:0]     pat,
  input  logic [7:0]     blow,
  input  logic [15:0]    aaddr,
  input  logic [7:0]     abank,
  input  logic [15:0]    cnt,
  input  logic [7:0]     a_rdata,
  input  logic [7:0]     b_rdata,
  output logic [CHW-1:0] cur_ch,
  output logic           active,
  output logic [23:0]    a_addr,
  output logic           a_rd,
  output logic           a_wr,
  output logic [7:0]     a_wdata,
  output logic [7:0]     b_addr,
  output logic           b_rd,
  output logic           b_wr,
  output logic [7:0]     b_wdata,
  output logic           upd_en,
  output logic [15:0]    upd_addr,
  output logic [15:0]    upd_cnt,
  output logic           done_en
);
  import dma_bridge_pkg::*;

  localparam logic [PHW-1:0] PH_CAP  = PHW'(1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(CPB - 1);

  logic           active_q;
  logic [CHW-1:0] ch_q;
  logic [PHW-1:0] ph_q;
  logic [1:0]     idx_q;
  logic [7:0]     hold_q;
  logic           rd_ph, wr_ph, last_byte;

  assign rd_ph     = active_q && (ph_q == '0);
  assign wr_ph     = active_q && (ph_q == PH_LAST);
  assign last_byte = (cnt == 16'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ch_q     <= '0;
      ph_q     <= '0;
      idx_q    <= '0;
      hold_q   <= '0;
    end else if (!active_q) begin
      if (go) begin
        active_q <= 1'b1;
        ch_q     <= pick_ch;
        ph_q     <= '0;
        idx_q    <= '0;
      end
    end else begin
      if (ph_q == PH_CAP) hold_q <= dir ? b_rdata : a_rdata;
      if (ph_q == PH_LAST) begin
        ph_q  <= '0;
        idx_q <= idx_q + 2'd1;
        if (last_byte) active_q <= 1'b0;
      end else begin
        ph_q <= ph_q + PHW'(1);
      end
    end
  end

  always_comb begin
    case (step_e'(step))
      STEP_UP:   upd_addr = aaddr + 16'd1;
      STEP_DOWN: upd_addr = aaddr - 16'd1;
      default:   upd_addr = aaddr;
    endcase
  end

  assign upd_cnt = cnt - 16'd1;
  assign upd_en  = wr_ph;
  assign done_en = wr_ph && last_byte;

  assign cur_ch  = ch_q;
  assign active  = active_q;
  assign a_addr  = {abank, aaddr};
  assign b_addr  = blow + {6'd0, pat_offset(pat, idx_q)};
  assign a_rd    = rd_ph && !dir;
  assign b_rd    = rd_ph && dir;
  assign b_wr    = wr_ph && !dir;
  assign a_wr    = wr_ph && dir;
  assign a_wdata = hold_q;
  assign b_wdata = hold_q;

endmodule

// File: rtl/dma_bridge.sv
module dma_bridge #(
  parameter int unsigned NCH          = 8,
  parameter int unsigned CYC_PER_BYTE = 4,
  parameter logic [15:0] WIN_BASE     = 16'h4300,
  parameter logic [15:0] START_ADDR   = 16'h420B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        busy,
  output logic [23:0] a_addr,
  output logic        a_rd,
  output logic        a_wr,
  output logic [7:0]  a_wdata,
  input  logic [7:0]  a_rdata,
  output logic [7:0]  b_addr,
  output logic        b_rd,
  output logic        b_wr,
  output logic [7:0]  b_wdata,
  input  logic [7:0]  b_rdata
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pend_q;
  logic [CHW-1:0] pick_ch, cur_ch;
  logic           active, go;
  logic           sel_dir;
  logic [1:0]     sel_step;
  logic [2:0]     sel_pat;
  logic [7:0]     sel_blow, sel_bank;
  logic [15:0]    sel_addr, sel_cnt;
  logic           upd_en, done_en;
  logic [15:0]    upd_addr, upd_cnt;

  assign busy = |pend_q;
  assign go   = busy && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (cpu_we && (cpu_addr == START_ADDR) && !busy) begin
      pend_q <= cpu_wdata[NCH-1:0];
    end else if (done_en) begin
      pend_q[cur_ch] <= 1'b0;
    end
  end

  dma_chan_regs #(.NCH(NCH), .WIN_BASE(WIN_BASE)) u_regs (
    .clk(clk), .rst(rst), .lock(busy),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sel_ch(cur_ch), .sel_dir(sel_dir), .sel_step(sel_step), .sel_pat(sel_pat),
    .sel_blow(sel_blow), .sel_addr(sel_addr), .sel_bank(sel_bank), .sel_cnt(sel_cnt),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_cnt(upd_cnt)
  );

  dma_chan_pick #(.NCH(NCH)) u_pick (
    .pend(pend_q), .pick_ch(pick_ch)
  );

  dma_byte_engine #(.NCH(NCH), .CPB(CYC_PER_BYTE)) u_eng (
    .clk(clk), .rst(rst), .go(go), .pick_ch(pick_ch),
    .dir(sel_dir), .step(sel_step), .pat(sel_pat), .blow(sel_blow),
    .aaddr(sel_addr), .abank(sel_bank), .cnt(sel_cnt),
    .a_rdata(a_rdata), .b_rdata(b_rdata),
    .cur_ch(cur_ch), .active(active),
    .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_wdata(a_wdata),
    .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_wdata(b_wdata),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_cnt(upd_cnt), .done_en(done_en)
  );

endmodule

// File: rtl/dma_bridge_chk.sv
module dma_bridge_chk #(
  parameter int unsigned CPB        = 4,
  parameter logic [15:0] START_ADDR = 16'h420B
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        cpu_we,
  input logic [15:0] cpu_addr,
  input logic        a_rd,
  input logic        a_wr,
  input logic        b_rd,
  input logic        b_wr
);
  localparam int unsigned SW = $clog2(CPB + 1) + 1;

  logic [SW-1:0] since_rd;
  logic          rd_from_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rd  <= '0;
      rd_from_a <= 1'b0;
    end else if (a_rd || b_rd) begin
      since_rd  <= SW'(1);
      rd_from_a <= a_rd;
    end else if (since_rd != SW'(CPB)) begin
      since_rd  <= since_rd + SW'(1);
    end
  end

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(a_rd || a_wr || b_rd || b_wr));

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cpu_we && (cpu_addr == START_ADDR)));

  p_single_access_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_rd, a_wr, b_rd, b_wr}));

  p_write_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    (a_wr || b_wr) |-> (since_rd == SW'(CPB - 1)));

  p_cross_bus_r4: assert property (@(posedge clk) disable iff (rst)
    (a_wr || b_wr) |-> (b_wr == rd_from_a));

endmodule

bind dma_bridge dma_bridge_chk #(.CPB(CYC_PER_BYTE), .START_ADDR(START_ADDR)) u_chk (.*);

// File: tb/tb_dma_bridge.sv
`timescale 1ns/1ps
module tb_dma_bridge;
  localparam int CPB = 4;
  localparam logic [15:0] STA = 16'h420B;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic busy;
  logic [23:0] a_addr;
  logic a_rd, a_wr, b_rd, b_wr;
  logic [7:0] a_wdata, b_wdata, b_addr;
  logic [7:0] a_rdata = '0, b_rdata = '0;

  always #2.5 clk = ~clk;

  dma_bridge #(.CYC_PER_BYTE(CPB)) dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .busy(busy), .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr),
    .b_wdata(b_wdata), .b_rdata(b_rdata));

  logic [7:0] amem [65536];
  logic [7:0] ref_a [65536];
  logic [7:0] bmem [256];
  logic [7:0] ref_b [256];
  logic [32:0] got_q [$];
  logic [32:0] exp_q [$];
  int cyc = 0, last_rd = 0, tmg_bad = 0, nchk = 0, nfail = 0;

  logic [7:0]  cmode [8];
  logic [7:0]  cblow [8];
  logic [15:0] caddr [8];
  logic [7:0]  cbank [8];
  logic [15:0] ccnt  [8];
  logic [15:0] cfin  [8];

  // Bus models: data comes back on the cycle after the strobe.
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (a_rd) a_rdata <= amem[a_addr[15:0]];
    if (b_rd) b_rdata <= bmem[b_addr];
    if (a_rd || b_rd) last_rd = cyc;
    if (a_wr) begin
      amem[a_addr[15:0]] <= a_wdata;
      got_q.push_back({1'b1, a_addr, a_wdata});
    end
    if (b_wr) begin
      bmem[b_addr] <= b_wdata;
      got_q.push_back({1'b0, 8'h00, 8'h21, b_addr, b_wdata});
    end
    if ((a_wr || b_wr) && (cyc - last_rd != CPB - 1)) tmg_bad = tmg_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  function automatic logic [1:0] exp_off(input logic [2:0] code, input int i);
    case (code)
      3'd1, 3'd5: return 2'(i % 2);
      3'd3, 3'd7: return 2'((i / 2) % 2);
      3'd4:       return 2'(i % 4);
      default:    return 2'd0;
    endcase
  endfunction

  task automatic program_ch(input int ch);
    logic [15:0] b = 16'h4300 + 16'(16 * ch);
    wr(b + 0, cmode[ch]); wr(b + 1, cblow[ch]);
    wr(b + 2, caddr[ch][7:0]); wr(b + 3, caddr[ch][15:8]);
    wr(b + 4, cbank[ch]);
    wr(b + 5, ccnt[ch][7:0]); wr(b + 6, ccnt[ch][15:8]);
  endtask

  task automatic model_run(input logic [7:0] mask);
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        logic [15:0] a = caddr[ch];
        for (int i = 0; i < int'(ccnt[ch]); i++) begin
          logic [7:0] bl = cblow[ch] + {6'd0, exp_off(cmode[ch][2:0], i)};
          logic [7:0] d;
          if (!cmode[ch][7]) begin
            d = ref_a[a]; ref_b[bl] = d;
            exp_q.push_back({1'b0, 8'h00, 8'h21, bl, d});
          end else begin
            d = ref_b[bl]; ref_a[a] = d;
            exp_q.push_back({1'b1, cbank[ch], a, d});
          end
          case (cmode[ch][4:3])
            2'd0: a = a + 16'd1;
            2'd2: a = a - 16'd1;
            default: ;
          endcase
        end
        cfin[ch] = a;
      end
    end
  endtask

  task automatic run(input logic [7:0] mask, input string tag);
    int bad;
    logic [7:0] lo, hi;
    exp_q.delete(); got_q.delete(); tmg_bad = 0;
    model_run(mask);
    wr(STA, mask);
    chk(busy === 1'b1, {"R2 busy after start ", tag}, busy, 1);
    while (busy) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {"R3 R9 write count ", tag}, got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
    if (bad >= 0) chk(1'b0, {"R3 R4 R5 R6 R7 R10 write stream ", tag}, got_q[bad], exp_q[bad]);
    else chk(1'b1, "R3", 0, 0);
    chk(tmg_bad == 0, {"R8 strobe spacing ", tag}, tmg_bad, 0);
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        rd(16'h4305 + 16'(16 * ch), lo); rd(16'h4306 + 16'(16 * ch), hi);
        chk({hi, lo} == 16'h0, {"R9 count cleared ", tag}, {hi, lo}, 0);
        rd(16'h4302 + 16'(16 * ch), lo); rd(16'h4303 + 16'(16 * ch), hi);
        chk({hi, lo} == cfin[ch], {"R9 final offset ", tag}, {hi, lo}, cfin[ch]);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    logic [7:0] mask;
    int n0, n1;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 65536; i++) begin amem[i] = 8'($urandom); ref_a[i] = amem[i]; end
    for (int i = 0; i < 256; i++) begin bmem[i] = 8'($urandom); ref_b[i] = bmem[i]; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk(busy === 1'b0, "R2 idle after reset", busy, 0);
    chk(!(a_rd || a_wr || b_rd || b_wr), "R2 no strobes at reset", {a_rd, a_wr, b_rd, b_wr}, 0);
    rd(16'h4375, v);
    chk(v == 8'h00, "R1 reset count reads 0", v, 0);

    // Register map readback
    wr(16'h4350, 8'hE5); wr(16'h4351, 8'h3C); wr(16'h4352, 8'h11); wr(16'h4353, 8'h22);
    wr(16'h4354, 8'h33); wr(16'h4355, 8'h44); wr(16'h4356, 8'h55); wr(16'h4359, 8'h99);
    rd(16'h4350, v); chk(v == 8'hE5, "R1 R10 mode readback", v, 8'hE5);
    rd(16'h4353, v); chk(v == 8'h22, "R1 offset high byte", v, 8'h22);
    rd(16'h4356, v); chk(v == 8'h55, "R1 count high byte", v, 8'h55);
    rd(16'h4359, v); chk(v == 8'h00, "R1 unused offset reads 0", v, 0);
    rd(16'h4380, v); chk(v == 8'h00, "R1 outside window reads 0", v, 0);
    rd(STA, v);      chk(v == 8'h00, "R1 start address reads 0", v, 0);

    // Multi-channel ordering with distinct setups
    cmode[0] = 8'h01; cblow[0] = 8'h18; caddr[0] = 16'h1000; cbank[0] = 8'h7E; ccnt[0] = 6;
    cmode[2] = 8'h83; cblow[2] = 8'h40; caddr[2] = 16'h2000; cbank[2] = 8'h01; ccnt[2] = 8;
    cmode[5] = 8'h14; cblow[5] = 8'h22; caddr[5] = 16'h3000; cbank[5] = 8'h00; ccnt[5] = 5;
    cmode[7] = 8'h97; cblow[7] = 8'h30; caddr[7] = 16'h3100; cbank[7] = 8'hC0; ccnt[7] = 7;
    program_ch(0); program_ch(2); program_ch(5); program_ch(7);
    run(8'hA5, "order");

    // Offset wraps upward and downward; bank stays put
    cmode[3] = 8'h80; cblow[3] = 8'h10; caddr[3] = 16'hFFFE; cbank[3] = 8'h7F; ccnt[3] = 4;
    cmode[4] = 8'h90; cblow[4] = 8'h11; caddr[4] = 16'h0001; cbank[4] = 8'h12; ccnt[4] = 3;
    program_ch(3); program_ch(4);
    run(8'h18, "R5 wrap");

    // Peripheral low byte wraps within the page; step 3 and code 6 aliases; bits 6/5 set
    cmode[1] = 8'h7C; cblow[1] = 8'hFE; caddr[1] = 16'h4444; cbank[1] = 8'h00; ccnt[1] = 6;
    cmode[6] = 8'h66; cblow[6] = 8'h50; caddr[6] = 16'h5000; cbank[6] = 8'h00; ccnt[6] = 5;
    program_ch(1); program_ch(6);
    run(8'h42, "R7 page wrap R6 alias");

    // Randomized runs
    for (int r = 0; r < 40; r++) begin
      mask = 8'($urandom);
      if (mask == 8'h00) mask = 8'h01;
      for (int ch = 0; ch < 8; ch++) begin
        if (mask[ch]) begin
          cmode[ch] = 8'($urandom);
          cblow[ch] = 8'($urandom);
          caddr[ch] = 16'($urandom);
          cbank[ch] = 8'($urandom);
          ccnt[ch]  = 16'(1 + ($urandom % 12));
          program_ch(ch);
        end
      end
      run(mask, "random");
    end

    // Writes while busy are ignored (R11)
    cmode[0] = 8'h00; cblow[0] = 8'h18; caddr[0] = 16'h0200; cbank[0] = 8'h00; ccnt[0] = 6;
    cmode[1] = 8'h00; cblow[1] = 8'h18; caddr[1] = 16'h0300; cbank[1] = 8'h00; ccnt[1] = 3;
    program_ch(0); program_ch(1);
    exp_q.delete(); got_q.delete(); tmg_bad = 0;
    model_run(8'h01);
    wr(STA, 8'h01);
    wr(16'h4300, 8'h80); wr(16'h4315, 8'h55); wr(STA, 8'h04);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R11 start during run ignored", busy, 0);
    chk(got_q.size() == exp_q.size(), "R11 only first run happened", got_q.size(), exp_q.size());
    n0 = 0;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) if (got_q[i] !== exp_q[i]) n0++;
    chk(n0 == 0, "R11 mode write during run ignored", n0, 0);
    rd(16'h4300, v); chk(v == 8'h00, "R11 mode unchanged", v, 0);
    rd(16'h4315, v); chk(v == 8'h03, "R11 count unchanged", v, 3);

    // Zero count means 65536 bytes; count register counts down (R9)
    cmode[0] = 8'h00; cblow[0] = 8'h04; caddr[0] = 16'h8000; cbank[0] = 8'h00; ccnt[0] = 0;
    program_ch(0);
    got_q.delete();
    wr(STA, 8'h01);
    while (got_q.size() < 5) @(negedge clk);
    @(negedge clk);
    cpu_addr = 16'h4305;
    n0 = got_q.size();
    @(negedge clk);
    n1 = got_q.size();
    v = cpu_rdata;
    chk((v >= 8'(256 - n1)) && (v <= 8'(256 - n0)), "R9 zero count counts down from 65536", v, 8'(256 - n0));
    rd(16'h4306, v2);
    chk(v2 == 8'hFF, "R9 zero count high byte", v2, 8'hFF);
    chk(busy === 1'b1, "R9 zero count still running", busy, 1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R2 reset ends run", busy, 0);
    rd(16'h4305, v);
    chk(v == 8'h00, "R1 count cleared by reset", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule